// File: doc/BRIEF.md
# Paged Program Address Unit

This block generates the program address for a small microcontroller whose program store is divided into pages of 128 words. It holds a 14-bit program counter that advances on fetch strobes and runs on across page edges. When an interrupt is accepted, the counter is loaded with a fixed vector address. A one-word call can jump into the dedicated subroutine page from any page. A return pops a small hardware stack of return addresses.

The same address bus also serves table reads of program-store data. A table read supplies a 6-bit page operand and a 7-bit word offset. A bank flag supplies the top page bit. The flag is set and cleared by explicit strobes. During a table read the bus carries the table address, and the low 8 bits of the returned word are latched as table data. The program counter is left untouched by the read. Instruction decoding, the program-store contents and the choice between competing interrupt sources are handled outside the block.

Top module: `pau_top`

## Requirements
- R1: While `rst_ni` is low and after its release, `rom_addr_o` is 0x0000, `tbl_data_o` is 0x00 and the bank flag is clear, so a table read issued right after reset drives address bit 13 as 0.
- R2: When `step_i` is the only active control strobe, the program counter increments by one on the next edge. It crosses page boundaries (0x017F to 0x0180) and wraps from 0x3FFF to 0x0000.
- R3: With no control strobe active, the program counter holds its value.
- R4: An accepted interrupt (`irq_i`) loads the counter with 0x0080 + 2 × `irq_src_i` and pushes the current counter value as the return address.
- R5: A call (`call_i`) loads the counter with 0x0100 + `call_off_i` (page 2) from any page and pushes the counter value plus one.
- R6: Each cycle follows the priority interrupt, call, return, table read, step. When an interrupt and a call arrive together, the call is dropped and only the interrupt's return address is pushed.
- R7: `ret_i` reloads the counter with the most recently pushed return address. Up to 4 nested pushes return in last-in, first-out order.
- R8: The return stack holds 4 entries and wraps silently. A fifth push overwrites the oldest entry, so five pops yield the fifth, fourth, third and second pushed addresses, then the fifth again.
- R9: While `tbl_rd_i` is high, `rom_addr_o` equals {bank, `tbl_page_i`, `tbl_off_i`} in the same cycle. The program counter holds even if `step_i` is also high.
- R10: At the end of a table-read cycle, `tbl_data_o` captures `rom_word_i[7:0]`. In cycles without a table read, `tbl_data_o` holds its value.
- R11: `bank_set_i` sets the bank flag and `bank_clr_i` clears it, with the clear winning when both are high. The new value applies to table reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance program counter |
| irq_i | input | 1 | Interrupt accepted |
| irq_src_i | input | 3 | Index of accepted interrupt source |
| call_i | input | 1 | One-word call into page 2 |
| call_off_i | input | 7 | Word offset of call target in page 2 |
| ret_i | input | 1 | Return from call or interrupt |
| bank_set_i | input | 1 | Select upper half of pages for table reads |
| bank_clr_i | input | 1 | Select lower half of pages for table reads |
| tbl_rd_i | input | 1 | Table read of program-store data |
| tbl_page_i | input | 6 | Page operand of table read |
| tbl_off_i | input | 7 | Word offset of table read |
| rom_word_i | input | 10 | Word returned by program store |
| rom_addr_o | output | 14 | Program-store address |
| tbl_data_o | output | 8 | Latched table data |

## Verification
The bench steps the counter through all 16384 addresses. A unit that stopped carrying at a page edge would loop inside one page, and one that saturated at the top would never return to 0x0000. Every call offset and every interrupt source is driven and then returned from. This catches a wrong vector stride, a call page other than 2, and a call that pushes its own address instead of the next one. Simultaneous interrupt and call, and five nested pushes, expose a wrong priority (a dropped interrupt or a double push) and a stack that saturates instead of wrapping. The table-read sweep covers every page in both banks with a step held high. It shows a bank flag that applies too early, a clear that fails to win, a counter that moves during a read, and data that fails to hold between reads.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [2:0] {
    PC_HOLD,
    PC_STEP,
    PC_VEC,
    PC_CALL,
    PC_RET
  } pc_sel_e;
endpackage

// File: rtl/pau_next_sel.sv
module pau_next_sel
  import pau_pkg::*;
(
  input  logic    step_i,
  input  logic    irq_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    tbl_rd_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o
);
  // fixed priority: interrupt, call, return, table read, step
  always_comb begin
    sel_o  = PC_HOLD;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (irq_i) begin
      sel_o  = PC_VEC;
      push_o = 1'b1;
    end else if (call_i) begin
      sel_o  = PC_CALL;
      push_o = 1'b1;
    end else if (ret_i) begin
      sel_o = PC_RET;
      pop_o = 1'b1;
    end else if (tbl_rd_i) begin
      sel_o = PC_HOLD;
    end else if (step_i) begin
      sel_o = PC_STEP;
    end
  end
endmodule

// File: rtl/pau_stack.sv
module pau_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  // DEPTH must be a power of two so the pointer wraps on its own
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] sp_q;
  logic [PW-1:0] top_idx;
  logic [W-1:0]  mem_q [DEPTH];

  assign top_idx = sp_q - PW'(1);
  assign dout_o  = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_q] <= din_i;
      sp_q        <= sp_q + PW'(1);
    end else if (pop_i) begin
      sp_q <= top_idx;
    end
  end
endmodule

// File: rtl/pau_tbl.sv
module pau_tbl #(
  parameter int PG_W  = 7,
  parameter int OFS_W = 7,
  parameter int ROM_W = 10,
  parameter int TBL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bank_set_i,
  input  logic                  bank_clr_i,
  input  logic                  tbl_rd_i,
  input  logic [PG_W-2:0]       tbl_page_i,
  input  logic [OFS_W-1:0]      tbl_off_i,
  input  logic [ROM_W-1:0]      rom_word_i,
  output logic [PG_W+OFS_W-1:0] tbl_addr_o,
  output logic [TBL_W-1:0]      tbl_data_o
);
  logic bank_q;
  logic unused_rom_hi;

  assign unused_rom_hi = ^rom_word_i[ROM_W-1:TBL_W];
  assign tbl_addr_o    = {bank_q, tbl_page_i, tbl_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
    end else if (bank_clr_i) begin
      bank_q <= 1'b0;
    end else if (bank_set_i) begin
      bank_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_data_o <= '0;
    end else if (tbl_rd_i) begin
      tbl_data_o <= rom_word_i[TBL_W-1:0];
    end
  end
endmodule

// File: rtl/pau_top.sv
module pau_top
  import pau_pkg::*;
#(
  parameter int OFS_W     = 7,
  parameter int PG_W      = 7,
  parameter int SRC_W     = 3,
  parameter int STK_DEPTH = 4,
  parameter int ROM_W     = 10,
  parameter int TBL_W     = 8,
  parameter int VEC_PAGE  = 1,
  parameter int CALL_PAGE = 2,
  localparam int PC_W     = OFS_W + PG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             irq_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             call_i,
  input  logic [OFS_W-1:0] call_off_i,
  input  logic             ret_i,
  input  logic             bank_set_i,
  input  logic             bank_clr_i,
  input  logic             tbl_rd_i,
  input  logic [PG_W-2:0]  tbl_page_i,
  input  logic [OFS_W-1:0] tbl_off_i,
  input  logic [ROM_W-1:0] rom_word_i,
  output logic [PC_W-1:0]  rom_addr_o,
  output logic [TBL_W-1:0] tbl_data_o
);
  localparam logic [PC_W-1:0] VEC_BASE = PC_W'(VEC_PAGE) << OFS_W;

  pc_sel_e         sel;
  logic            push, pop;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, vec_addr, call_addr, stk_top, push_val, tbl_addr;

  pau_next_sel u_sel (
    .step_i  (step_i),
    .irq_i   (irq_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .tbl_rd_i(tbl_rd_i),
    .sel_o   (sel),
    .push_o  (push),
    .pop_o   (pop)
  );

  assign pc_inc    = pc_q + PC_W'(1);
  // vectors sit on two-word steps
  assign vec_addr  = VEC_BASE + PC_W'({irq_src_i, 1'b0});
  assign call_addr = {PG_W'(CALL_PAGE), call_off_i};
  // interrupted instruction is re-fetched; a call resumes after itself
  assign push_val  = irq_i ? pc_q : pc_inc;

  pau_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .din_i (push_val),
    .dout_o(stk_top)
  );

  always_comb begin
    case (sel)
      PC_STEP: pc_d = pc_inc;
      PC_VEC:  pc_d = vec_addr;
      PC_CALL: pc_d = call_addr;
      PC_RET:  pc_d = stk_top;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  pau_tbl #(.PG_W(PG_W), .OFS_W(OFS_W), .ROM_W(ROM_W), .TBL_W(TBL_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_set_i(bank_set_i),
    .bank_clr_i(bank_clr_i),
    .tbl_rd_i  (tbl_rd_i),
    .tbl_page_i(tbl_page_i),
    .tbl_off_i (tbl_off_i),
    .rom_word_i(rom_word_i),
    .tbl_addr_o(tbl_addr),
    .tbl_data_o(tbl_data_o)
  );

  assign rom_addr_o = tbl_rd_i ? tbl_addr : pc_q;
endmodule

// File: rtl/pau_checker.sv
module pau_checker #(
  parameter int OFS_W = 7,
  parameter int PG_W  = 7,
  parameter int SRC_W = 3,
  parameter int ROM_W = 10,
  parameter int TBL_W = 8,
  localparam int PC_W = OFS_W + PG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             irq_i,
  input logic [SRC_W-1:0] irq_src_i,
  input logic             call_i,
  input logic [OFS_W-1:0] call_off_i,
  input logic             ret_i,
  input logic             tbl_rd_i,
  input logic [PG_W-2:0]  tbl_page_i,
  input logic [OFS_W-1:0] tbl_off_i,
  input logic [ROM_W-1:0] rom_word_i,
  input logic [PC_W-1:0]  rom_addr_o,
  input logic [TBL_W-1:0] tbl_data_o
);
  logic only_step, idle;
  assign only_step = step_i && !irq_i && !call_i && !ret_i && !tbl_rd_i;
  assign idle      = !step_i && !irq_i && !call_i && !ret_i && !tbl_rd_i;

  p_step_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_step |=> tbl_rd_i || (rom_addr_o == $past(rom_addr_o) + PC_W'(1)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> tbl_rd_i || (rom_addr_o == $past(rom_addr_o)));

  p_vector_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> tbl_rd_i ||
      (rom_addr_o == (PC_W'(1) << OFS_W) + PC_W'({$past(irq_src_i), 1'b0})));

  p_call_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !irq_i) |=> tbl_rd_i || (rom_addr_o == {PG_W'(2), $past(call_off_i)}));

  p_irq_over_call_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && irq_i) |=> tbl_rd_i || (rom_addr_o[OFS_W +: PG_W] == PG_W'(1)));

  p_tbl_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_rd_i |-> rom_addr_o[PC_W-2:0] == {tbl_page_i, tbl_off_i});

  p_tbl_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_rd_i |=> tbl_data_o == $past(rom_word_i[TBL_W-1:0]));

  p_tbl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tbl_rd_i |=> $stable(tbl_data_o));
endmodule

bind pau_top pau_checker #(
  .OFS_W(OFS_W), .PG_W(PG_W), .SRC_W(SRC_W), .ROM_W(ROM_W), .TBL_W(TBL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_i    (step_i),
  .irq_i     (irq_i),
  .irq_src_i (irq_src_i),
  .call_i    (call_i),
  .call_off_i(call_off_i),
  .ret_i     (ret_i),
  .tbl_rd_i  (tbl_rd_i),
  .tbl_page_i(tbl_page_i),
  .tbl_off_i (tbl_off_i),
  .rom_word_i(rom_word_i),
  .rom_addr_o(rom_addr_o),
  .tbl_data_o(tbl_data_o)
);

// File: tb/pau_top_tb.sv
`timescale 1ns/1ps
module pau_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, irq = 1'b0, call = 1'b0, ret = 1'b0;
  logic        bset = 1'b0, bclr = 1'b0, tbl = 1'b0;
  logic [2:0]  src = '0;
  logic [6:0]  coff = '0, toff = '0;
  logic [5:0]  tpg = '0;
  logic [9:0]  rom_word;
  logic [13:0] rom_addr;
  logic [7:0]  tdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [13:0] m_pc = '0;
  logic [13:0] m_stk [4];
  logic [1:0]  m_sp = '0;
  logic        m_bank = 1'b0;
  logic [7:0]  m_tdata = '0;

  always #4 clk = ~clk;

  function automatic logic [9:0] romf(input logic [13:0] a);
    return 10'(a * 7) ^ 10'(a >> 4);
  endfunction

  assign rom_word = romf(rom_addr);

  pau_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .irq_i(irq), .irq_src_i(src),
    .call_i(call), .call_off_i(coff), .ret_i(ret), .bank_set_i(bset),
    .bank_clr_i(bclr), .tbl_rd_i(tbl), .tbl_page_i(tpg), .tbl_off_i(toff),
    .rom_word_i(rom_word), .rom_addr_o(rom_addr), .tbl_data_o(tdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic s, input logic i, input logic [2:0] sr,
                     input logic c, input logic [6:0] co, input logic r, input logic bs,
                     input logic bc, input logic t, input logic [5:0] pg, input logic [6:0] to);
    logic [13:0] taddr;
    step = s; irq = i; src = sr; call = c; coff = co; ret = r;
    bset = bs; bclr = bc; tbl = t; tpg = pg; toff = to;
    taddr = {m_bank, pg, to};
    #1;
    if (t) chk({tag, " table address"}, 32'(rom_addr), 32'(taddr));
    @(posedge clk);
    if (t) m_tdata = romf(taddr)[7:0];
    if (bc) m_bank = 1'b0;
    else if (bs) m_bank = 1'b1;
    if (i) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 2'd1; m_pc = 14'h0080 + 14'({sr, 1'b0});
    end else if (c) begin
      m_stk[m_sp] = m_pc + 14'd1; m_sp = m_sp + 2'd1; m_pc = {7'd2, co};
    end else if (r) begin
      m_sp = m_sp - 2'd1; m_pc = m_stk[m_sp];
    end else if (!t && s) begin
      m_pc = m_pc + 14'd1;
    end
    @(negedge clk);
    step = 0; irq = 0; call = 0; ret = 0; bset = 0; bclr = 0; tbl = 0;
    #1;
    chk({tag, " pc"}, 32'(rom_addr), 32'(m_pc));
    chk({tag, " table data"}, 32'(tdata), 32'(m_tdata));
  endtask

  task automatic do_step(input string tag);
    cyc(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_irq(input string tag, input logic [2:0] s);
    cyc(tag, 1, 1, s, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_call(input string tag, input logic [6:0] o);
    cyc(tag, 1, 0, 0, 1, o, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_ret(input string tag);
    cyc(tag, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic do_tbl(input string tag, input logic [5:0] pg, input logic [6:0] o);
    cyc(tag, 1, 0, 0, 0, 0, 0, 0, 0, 1, pg, o);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_stk[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr in reset", 32'(rom_addr), 0);
    chk("R1 data in reset", 32'(tdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 addr after reset", 32'(rom_addr), 0);
    chk("R1 data after reset", 32'(tdata), 0);
    do_tbl("R1 bank clear", 6'd63, 7'd127);

    for (int k = 0; k < 3; k++) do_idle("R3 idle hold");

    // full address sweep incl. page edges and top wrap
    for (int k = 0; k < 16384; k++) do_step("R2 sweep");
    chk("R2 wrapped to zero", 32'(rom_addr), 0);

    for (int o = 0; o < 128; o++) begin
      for (int k = 0; k < 37; k++) do_step("R2 spread");
      do_call("R5 call offset", 7'(o));
      do_ret("R7 return from call");
    end

    do_call("R5 call near page end", 7'h7E);
    for (int k = 0; k < 3; k++) do_step("R2 run past page 2");
    chk("R2 crossed into page 3", 32'(rom_addr), 32'h0181);
    do_ret("R7 return after long subroutine");

    for (int s = 0; s < 8; s++) begin
      do_step("R2 pre irq");
      do_irq("R4 vector", 3'(s));
      do_idle("R3 hold at vector");
      do_ret("R7 return from irq");
    end

    cyc("R6 irq over call", 0, 1, 3'd5, 1, 7'd9, 0, 0, 0, 0, 0, 0);
    chk("R6 vector taken", 32'(rom_addr), 32'h008A);
    do_ret("R6 single push return");

    do_irq("R7 nest1", 3'd1);
    do_call("R7 nest2", 7'd10);
    do_call("R7 nest3", 7'd20);
    do_irq("R7 nest4", 3'd6);
    for (int k = 0; k < 4; k++) do_ret("R7 lifo pop");

    for (int k = 1; k <= 5; k++) begin
      do_step("R2 pre call");
      do_call("R8 overflow push", 7'(k * 3));
    end
    for (int k = 0; k < 5; k++) do_ret("R8 wrapped pop");

    for (int b = 0; b < 2; b++) begin
      if (b == 1) cyc("R11 set bank", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      for (int p = 0; p < 64; p++) begin
        do_tbl("R9 table sweep", 6'(p), 7'((p * 5 + b * 3) & 127));
        do_step("R10 data hold");
      end
    end

    cyc("R11 set and clear", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    do_tbl("R11 clear wins", 6'd10, 7'd1);
    cyc("R11 set with read", 0, 0, 0, 0, 0, 0, 1, 0, 1, 6'd2, 7'd3);
    do_tbl("R11 set now visible", 6'd2, 7'd3);
    cyc("R11 clear with read", 0, 0, 0, 0, 0, 0, 0, 1, 1, 6'd4, 7'd5);
    do_tbl("R11 clear now visible", 6'd4, 7'd5);
    for (int k = 0; k < 3; k++) do_step("R10 hold after read");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule